// File: doc/BRIEF.md
# Guarded Action Arbitration Scheduler

This block decides, on every clock, which of a set of guarded actions may commit their state updates. Each action presents one enable bit: its guard, already evaluated on the current state. The block returns one grant bit per action. Two fixed tables, set as parameters, shape the decision. A pairwise conflict table marks the pairs of actions that must not commit in the same cycle. An urgency ranking decides which action of such a pair wins. Any pair that is left unmarked is taken to be independent or safely ordered, so it may commit together.

The grant bits also drive a small bank of shared registers. Each register has a fixed set of writer actions. Its write enable is the OR of those writers' grants, and it loads the data word of the granted writer at the next rising edge. Two writers of the same register are always treated as conflicting, even when the conflict table leaves the pair unmarked. A serial mode input limits the scheduler to a single grant per cycle. The grant path is purely combinational and one AND-OR level deep, and no state carries from one cycle into the next decision. The register bank has no handshake: a write takes effect at the first edge after the grant.

Top module: `guarded_action_sched`

## Requirements
- R1: A will_fire bit is high only when the matching can_fire bit is high.
- R2: When any can_fire bit is high, at least one will_fire bit is high.
- R3: With serial_mode high, the scheduler grants only the enabled action of best urgency rank, so at most one will_fire bit is high.
- R4: With serial_mode low, action a is granted if and only if it is enabled and no enabled action of better urgency rank conflicts with it. Conflict is symmetric. Rank 0 is the most urgent, and slot k of URG_ORDER (bits k*IW upward) holds the index of the action with rank k. The default order is 2, 0, 3, 1 from most to least urgent, and the default conflict table marks only the pair 0/1.
- R5: Two actions that write the same register are treated as conflicting, so no two writers of one register are granted together. By default register 0 is written by actions 0 and 2, and register 1 by actions 1 and 3.
- R6: Grants follow the current can_fire and serial_mode inputs within the same cycle, with no memory of earlier decisions.
- R7: reg_we[r] is the OR of the grants of the writers of register r. At the next rising edge, register r (reg_q bits r*DW upward) takes the word of the granted writer a (act_wdata bits a*DW upward).
- R8: All registers reset to zero, and a register whose reg_we bit is low keeps its value across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset for the register bank |
| serial_mode | input | 1 | High: one grant per cycle at most |
| can_fire | input | N_ACT | Guard of each action |
| act_wdata | input | N_ACT*DW | Write data word of each action |
| will_fire | output | N_ACT | Grant of each action |
| reg_we | output | N_REG | Write enable of each shared register |
| reg_q | output | N_REG*DW | Current value of each shared register |

## Verification
The grant logic is exercised with several kinds of input. An all-enabled vector shows whether an action blocked by a conflict can still block a less urgent action. Pairs that conflict only through a shared register separate the register-derived conflicts from the table conflicts. A pair with no conflict at all shows whether the scheduler grants more than one action per cycle. The same vectors are then applied in serial mode to confirm that the urgency ranking alone picks the single winner. Register writes alternate between the two registers, so each write also checks that the other register holds. A long random run in both modes compares every grant vector with a reference model built from the ranking and the conflict pairs.

// File: rtl/gas_pkg.sv
package gas_pkg;
  typedef enum logic {
    MODE_CONCURRENT = 1'b0,
    MODE_SERIAL     = 1'b1
  } gas_mode_e;

  function automatic int pair_idx(input int row, input int col, input int width);
    return row * width + col;
  endfunction
endpackage

// File: rtl/gas_rank.sv
module gas_rank #(
  parameter int N_ACT = 4,
  parameter int IW = 2,
  parameter logic [N_ACT*IW-1:0] URG_ORDER = '0
) (
  output logic [N_ACT*N_ACT-1:0] beats
);
  logic [IW:0] rank_of [N_ACT];

  always_comb begin
    for (int a = 0; a < N_ACT; a++) begin
      rank_of[a] = '0;
      for (int k = 0; k < N_ACT; k++) begin
        if (int'(URG_ORDER[k*IW +: IW]) == a) rank_of[a] = (IW+1)'(k);
      end
    end
  end

  for (genvar i = 0; i < N_ACT; i++) begin : g_row
    for (genvar j = 0; j < N_ACT; j++) begin : g_col
      assign beats[i*N_ACT+j] = (rank_of[i] < rank_of[j]);
    end
  end
endmodule

// File: rtl/gas_grant.sv
module gas_grant
  import gas_pkg::*;
#(
  parameter int N_ACT = 4,
  parameter int N_REG = 2,
  parameter logic [N_ACT*N_ACT-1:0] CONFLICT = '0,
  parameter logic [N_REG*N_ACT-1:0] WRITERS = '0
) (
  input  gas_mode_e          mode,
  input  logic [N_ACT-1:0]   can_fire,
  input  logic [N_ACT*N_ACT-1:0] beats,
  output logic [N_ACT-1:0]   will_fire
);
  function automatic logic [N_ACT*N_ACT-1:0] build_conf();
    logic [N_ACT*N_ACT-1:0] m;
    m = '0;
    for (int i = 0; i < N_ACT; i++) begin
      for (int j = 0; j < N_ACT; j++) begin
        if (i != j) begin
          if (CONFLICT[pair_idx(i, j, N_ACT)] || CONFLICT[pair_idx(j, i, N_ACT)])
            m[pair_idx(i, j, N_ACT)] = 1'b1;
          for (int r = 0; r < N_REG; r++) begin
            if (WRITERS[r*N_ACT+i] && WRITERS[r*N_ACT+j])
              m[pair_idx(i, j, N_ACT)] = 1'b1;
          end
        end
      end
    end
    return m;
  endfunction

  localparam logic [N_ACT*N_ACT-1:0] EFF_CONF = build_conf();

  for (genvar j = 0; j < N_ACT; j++) begin : g_act
    logic [N_ACT-1:0] blockers;
    always_comb begin
      for (int i = 0; i < N_ACT; i++) begin
        blockers[i] = beats[i*N_ACT+j] &&
                      ((mode == MODE_SERIAL) || EFF_CONF[i*N_ACT+j]);
      end
    end
    assign will_fire[j] = can_fire[j] && !(|(can_fire & blockers));
  end
endmodule

// File: rtl/gas_regmux.sv
module gas_regmux #(
  parameter int N_ACT = 4,
  parameter int N_REG = 2,
  parameter int DW = 8,
  parameter logic [N_REG*N_ACT-1:0] WRITERS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_ACT-1:0]      grant,
  input  logic [N_ACT*DW-1:0]   wdata,
  output logic [N_REG-1:0]      we,
  output logic [N_REG*DW-1:0]   q
);
  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    logic [N_ACT-1:0] sel;
    logic [DW-1:0]    nxt;
    logic [DW-1:0]    store;

    assign sel   = grant & WRITERS[r*N_ACT +: N_ACT];
    assign we[r] = |sel;

    always_comb begin
      nxt = '0;
      for (int a = 0; a < N_ACT; a++) begin
        nxt = nxt | ({DW{sel[a]}} & wdata[a*DW +: DW]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     store <= '0;
      else if (we[r]) store <= nxt;
    end

    assign q[r*DW +: DW] = store;
  end
endmodule

// File: rtl/guarded_action_sched.sv
module guarded_action_sched
  import gas_pkg::*;
#(
  parameter int N_ACT = 4,
  parameter int N_REG = 2,
  parameter int DW = 8,
  parameter int IW = (N_ACT > 1) ? $clog2(N_ACT) : 1,
  parameter logic [N_ACT*IW-1:0] URG_ORDER = {2'd1, 2'd3, 2'd0, 2'd2},
  parameter logic [N_ACT*N_ACT-1:0] CONFLICT = 16'h0002,
  parameter logic [N_REG*N_ACT-1:0] WRITERS = {4'b1010, 4'b0101}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                serial_mode,
  input  logic [N_ACT-1:0]    can_fire,
  input  logic [N_ACT*DW-1:0] act_wdata,
  output logic [N_ACT-1:0]    will_fire,
  output logic [N_REG-1:0]    reg_we,
  output logic [N_REG*DW-1:0] reg_q
);
  logic [N_ACT*N_ACT-1:0] beats;
  gas_mode_e              mode;

  assign mode = serial_mode ? MODE_SERIAL : MODE_CONCURRENT;

  gas_rank #(.N_ACT(N_ACT), .IW(IW), .URG_ORDER(URG_ORDER)) u_rank (
    .beats(beats)
  );

  gas_grant #(.N_ACT(N_ACT), .N_REG(N_REG), .CONFLICT(CONFLICT), .WRITERS(WRITERS)) u_grant (
    .mode(mode), .can_fire(can_fire), .beats(beats), .will_fire(will_fire)
  );

  gas_regmux #(.N_ACT(N_ACT), .N_REG(N_REG), .DW(DW), .WRITERS(WRITERS)) u_regs (
    .clk(clk), .rst_n(rst_n), .grant(will_fire), .wdata(act_wdata),
    .we(reg_we), .q(reg_q)
  );
endmodule

// File: rtl/gas_checker.sv
module gas_checker #(
  parameter int N_ACT = 4,
  parameter int N_REG = 2,
  parameter int DW = 8,
  parameter logic [N_ACT*N_ACT-1:0] CONFLICT = '0,
  parameter logic [N_REG*N_ACT-1:0] WRITERS = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                serial_mode,
  input logic [N_ACT-1:0]    can_fire,
  input logic [N_ACT-1:0]    will_fire,
  input logic [N_REG-1:0]    reg_we,
  input logic [N_REG*DW-1:0] reg_q
);
  assert_grant_within_guard_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (will_fire & ~can_fire) == '0);

  assert_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (can_fire != '0) |-> (will_fire != '0));

  assert_serial_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    serial_mode |-> $onehot0(will_fire));

  for (genvar i = 0; i < N_ACT; i++) begin : g_pi
    for (genvar j = i + 1; j < N_ACT; j++) begin : g_pj
      if (CONFLICT[i*N_ACT+j] || CONFLICT[j*N_ACT+i]) begin : g_c
        assert_no_conflict_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
          !(will_fire[i] && will_fire[j]));
      end
    end
  end

  for (genvar r = 0; r < N_REG; r++) begin : g_r
    assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(will_fire & WRITERS[r*N_ACT +: N_ACT]));
    assert_we_from_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we[r] == |(will_fire & WRITERS[r*N_ACT +: N_ACT]));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we[r] |=> $stable(reg_q[r*DW +: DW]));
  end
endmodule

bind guarded_action_sched gas_checker #(
  .N_ACT(N_ACT), .N_REG(N_REG), .DW(DW), .CONFLICT(CONFLICT), .WRITERS(WRITERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .can_fire(can_fire),
  .will_fire(will_fire), .reg_we(reg_we), .reg_q(reg_q)
);

// File: tb/guarded_action_sched_bench.sv
module guarded_action_sched_bench;
  localparam int N = 4;
  localparam int NR = 2;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            serial_mode = 1'b0;
  logic [N-1:0]    can_fire = '0;
  logic [N*DW-1:0] act_wdata = '0;
  logic [N-1:0]    will_fire;
  logic [NR-1:0]   reg_we;
  logic [NR*DW-1:0] reg_q;

  int checks = 0;
  int failures = 0;

  // urgency rank of each action (R4 default: order 2,0,3,1)
  int rank_tab [N] = '{1, 3, 0, 2};

  always #2 clk = ~clk;

  guarded_action_sched u_guarded_action_sched (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .can_fire(can_fire),
    .act_wdata(act_wdata), .will_fire(will_fire), .reg_we(reg_we), .reg_q(reg_q)
  );

  // R4 table pair 0/1, R5 shared writers 0/2 and 1/3
  function automatic bit conflicts(int i, int j);
    int lo = (i < j) ? i : j;
    int hi = (i < j) ? j : i;
    return (lo == 0 && hi == 1) || (lo == 0 && hi == 2) || (lo == 1 && hi == 3);
  endfunction

  function automatic logic [N-1:0] ref_grant(logic [N-1:0] cf, logic ser);
    logic [N-1:0] g = '0;
    for (int a = 0; a < N; a++) begin
      bit blk = 1'b0;
      for (int b = 0; b < N; b++)
        if (cf[b] && rank_tab[b] < rank_tab[a] && (ser || conflicts(a, b))) blk = 1'b1;
      g[a] = cf[a] && !blk;
    end
    return g;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic ser, logic [N-1:0] cf);
    @(negedge clk);
    serial_mode = ser;
    can_fire = cf;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    can_fire = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset value", 32'(reg_q), 32'h0);
    chk("R1 no grant when idle", 32'(will_fire), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_concurrent();
    drive(1'b0, 4'b1111); chk("R4 all enabled", 32'(will_fire), 32'b1100);
    drive(1'b0, 4'b0011); chk("R4 table conflict 0/1", 32'(will_fire), 32'b0001);
    drive(1'b0, 4'b1010); chk("R5 shared writer 1/3", 32'(will_fire), 32'b1000);
    drive(1'b0, 4'b0101); chk("R5 shared writer 0/2", 32'(will_fire), 32'b0100);
    drive(1'b0, 4'b0110); chk("R4 independent pair", 32'(will_fire), 32'b0110);
    drive(1'b0, 4'b0010); chk("R2 lone least urgent", 32'(will_fire), 32'b0010);
  endtask

  task automatic t_serial();
    drive(1'b1, 4'b1111); chk("R3 serial all", 32'(will_fire), 32'b0100);
    drive(1'b1, 4'b0110); chk("R3 serial no conflict", 32'(will_fire), 32'b0100);
    drive(1'b1, 4'b1010); chk("R3 serial 1/3", 32'(will_fire), 32'b1000);
    drive(1'b0, 4'b0110); chk("R6 mode switch same cycle", 32'(will_fire), 32'b0110);
  endtask

  task automatic t_regs();
    act_wdata = {8'h33, 8'h22, 8'h11, 8'hAA};
    drive(1'b0, 4'b0110);
    chk("R7 write enables both", 32'(reg_we), 32'b11);
    @(posedge clk); #1;
    chk("R7 both registers loaded", 32'(reg_q), 32'h1122);
    drive(1'b0, 4'b0011);
    chk("R7 enable reg0 only", 32'(reg_we), 32'b01);
    @(posedge clk); #1;
    chk("R8 reg1 holds, reg0 from action 0", 32'(reg_q), 32'h11AA);
    drive(1'b0, 4'b1010);
    @(posedge clk); #1;
    chk("R7 reg1 from action 3", 32'(reg_q), 32'h33AA);
    drive(1'b1, 4'b0101);
    @(posedge clk); #1;
    chk("R7 serial write reg0 from action 2", 32'(reg_q), 32'h3322);
    drive(1'b0, 4'b0000);
    chk("R7 no enable when idle", 32'(reg_we), 32'b00);
    repeat (2) @(posedge clk); #1;
    chk("R8 idle hold", 32'(reg_q), 32'h3322);
  endtask

  task automatic t_random();
    for (int it = 0; it < 400; it++) begin
      logic ser = 1'($urandom);
      logic [N-1:0] cf = N'($urandom);
      drive(ser, cf);
      chk("R4 reference grant", 32'(will_fire), 32'(ref_grant(cf, ser)));
      if ((will_fire & ~cf) != '0) chk("R1 subset", 32'(will_fire), 32'(will_fire & cf));
      if (cf != '0 && will_fire == '0) chk("R2 progress", 32'(will_fire), 32'h1);
      if (ser && !$onehot0(will_fire)) chk("R3 onehot", 32'(will_fire), 32'h0);
      if ((will_fire[0] && will_fire[2]) || (will_fire[1] && will_fire[3]))
        chk("R5 writer exclusivity", 32'(will_fire), 32'h0);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_concurrent();
        t_serial();
        t_regs();
        t_random();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule